// File: doc/BRIEF.md
# Compare-Interrupt Up-Timer (24-bit)

This block is a 24-bit up-counting timer with a reload latch and a 24-bit compare register. Software reaches all three through a narrow register bus in 12-bit halves. The counter advances by one on each cycle in which the tick enable is high. When it passes its maximum it either wraps to zero or reloads from the latch, chosen by a one-bit mode input.

A compare flag goes high when the count first becomes strictly greater than the programmed compare value. It does not rise again until the count has dropped back to or below that value and crossed it once more. Writing the upper half of the count reloads the counter and clears the flag. A separate clear input also clears the flag. Enabling, masking and combining this flag with other interrupt sources is left to the surrounding logic.

Top module: `cmp_timer24`

## Requirements
- R1: After reset the counter and the latch read zero, the compare value reads all ones in both halves, and `cmp_flag` is low.
- R2: Address 0 reads counter bits 11:0 and address 1 reads counter bits 23:12. A write to address 0 changes only latch bits 11:0 and leaves the counter unchanged.
- R3: A write to address 1 loads the counter with {write data, latch bits 11:0} at the next clock edge and leaves latch bits 23:12 unchanged.
- R4: Addresses 2 and 3 read and write latch bits 11:0 and 23:12. Addresses 4 and 5 read and write compare bits 11:0 and 23:12. Addresses 6 and 7 read zero, and writes to them change nothing.
- R5: With `tick_en` high the counter rises by one per clock. With `tick_en` low it holds. A write to address 1 takes precedence over counting.
- R6: With `reload_mode` = 0, a tick at count 0xFFFFFF gives a count of zero.
- R7: With `reload_mode` = 1, a tick at count 0xFFFFFF loads the full 24-bit latch value.
- R8: `cmp_flag` rises one clock after the first cycle in which the count is strictly greater than the compare value. A count equal to the compare value never sets it.
- R9: The flag is set once per crossing. After a clear it stays low while the count remains above the compare value.
- R10: A pulse on `flag_clr` or a write to address 1 clears `cmp_flag`. A new crossing in the same cycle as `flag_clr` wins over the clear. A write to address 1 wins over a crossing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_cs | input | 1 | Register access select |
| bus_we | input | 1 | Write strobe, qualified by bus_cs |
| bus_addr | input | 3 | Register address (0..5 used) |
| bus_wdata | input | 12 | Write data |
| bus_rdata | output | 12 | Read data for bus_addr (combinational) |
| tick_en | input | 1 | Count enable, one step per cycle while high |
| reload_mode | input | 1 | 0: wrap to zero, 1: reload from latch on wrap |
| flag_clr | input | 1 | Clears the compare flag |
| cmp_flag | output | 1 | Compare interrupt flag |

## Verification
A corrupted counter or latch shows on the bus as soon as the affected half is read back. It also shows one tick after a wrap, because the reload value then appears at address 0 and address 1. A stale or missing edge history shows in `cmp_flag`. The flag then rises a cycle early or late relative to the count reaching compare+1, rises again after a clear while the count is still above the compare value, or never rises at all. Each of these differences appears within one clock of the crossing or the clear.

// File: rtl/cmp_timer24_pkg.sv
package cmp_timer24_pkg;

    localparam int DEF_HALF_W = 12;
    localparam int REG_ADDR_W = 3;

    typedef enum logic [REG_ADDR_W-1:0] {
        REG_CNT_LO = 3'd0,
        REG_CNT_HI = 3'd1,
        REG_LAT_LO = 3'd2,
        REG_LAT_HI = 3'd3,
        REG_CMP_LO = 3'd4,
        REG_CMP_HI = 3'd5
    } reg_sel_e;

    typedef struct packed {
        logic cnt_lo;
        logic cnt_hi;
        logic lat_lo;
        logic lat_hi;
        logic cmp_lo;
        logic cmp_hi;
    } wr_strb_t;

    function automatic wr_strb_t decode_wr(input logic cs, input logic we,
                                           input logic [REG_ADDR_W-1:0] a);
        wr_strb_t s;
        s = '0;
        if (cs && we) begin
            case (a)
                REG_CNT_LO: s.cnt_lo = 1'b1;
                REG_CNT_HI: s.cnt_hi = 1'b1;
                REG_LAT_LO: s.lat_lo = 1'b1;
                REG_LAT_HI: s.lat_hi = 1'b1;
                REG_CMP_LO: s.cmp_lo = 1'b1;
                REG_CMP_HI: s.cmp_hi = 1'b1;
                default:    s = '0;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/cmp_timer24_bus_dec.sv
module cmp_timer24_bus_dec
    import cmp_timer24_pkg::*;
(
    input  logic                  cs,
    input  logic                  we,
    input  logic [REG_ADDR_W-1:0] addr,
    output wr_strb_t              strb
);
    always_comb strb = decode_wr(cs, we, addr);
endmodule

// File: rtl/cmp_timer24_counter.sv
module cmp_timer24_counter #(
    parameter int HALF_W = 12
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tick_en,
    input  logic                reload_mode,
    input  logic                wr_cnt_lo,
    input  logic                wr_cnt_hi,
    input  logic                wr_lat_lo,
    input  logic                wr_lat_hi,
    input  logic [HALF_W-1:0]   wdata,
    output logic [2*HALF_W-1:0] cnt_q,
    output logic [2*HALF_W-1:0] latch_q
);
    localparam int CNT_W = 2 * HALF_W;
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q <= '0;
        end else begin
            if (wr_cnt_lo || wr_lat_lo) latch_q[HALF_W-1:0]     <= wdata;
            if (wr_lat_hi)              latch_q[CNT_W-1:HALF_W] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (wr_cnt_hi) begin
            cnt_q <= {wdata, latch_q[HALF_W-1:0]};
        end else if (tick_en) begin
            if (cnt_q == CNT_MAX) cnt_q <= reload_mode ? latch_q : '0;
            else                  cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/cmp_timer24_compare.sv
module cmp_timer24_compare #(
    parameter int HALF_W = 12
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_cmp_lo,
    input  logic                wr_cmp_hi,
    input  logic                wr_cnt_hi,
    input  logic                flag_clr,
    input  logic [HALF_W-1:0]   wdata,
    input  logic [2*HALF_W-1:0] cnt_q,
    output logic [2*HALF_W-1:0] cmp_q,
    output logic                flag_q
);
    localparam int CNT_W = 2 * HALF_W;

    logic above;
    logic above_q;

    assign above = (cnt_q > cmp_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_q <= {CNT_W{1'b1}};
        end else begin
            if (wr_cmp_lo) cmp_q[HALF_W-1:0]     <= wdata;
            if (wr_cmp_hi) cmp_q[CNT_W-1:HALF_W] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            above_q <= 1'b0;
            flag_q  <= 1'b0;
        end else begin
            above_q <= above;
            if (wr_cnt_hi)              flag_q <= 1'b0;
            else if (above && !above_q) flag_q <= 1'b1;
            else if (flag_clr)          flag_q <= 1'b0;
        end
    end
endmodule

// File: rtl/cmp_timer24.sv
module cmp_timer24
    import cmp_timer24_pkg::*;
#(
    parameter int HALF_W = DEF_HALF_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bus_cs,
    input  logic                  bus_we,
    input  logic [REG_ADDR_W-1:0] bus_addr,
    input  logic [HALF_W-1:0]     bus_wdata,
    output logic [HALF_W-1:0]     bus_rdata,
    input  logic                  tick_en,
    input  logic                  reload_mode,
    input  logic                  flag_clr,
    output logic                  cmp_flag
);
    localparam int CNT_W = 2 * HALF_W;

    wr_strb_t         strb;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] latch_q;
    logic [CNT_W-1:0] cmp_q;

    cmp_timer24_bus_dec u_dec (
        .cs   (bus_cs),
        .we   (bus_we),
        .addr (bus_addr),
        .strb (strb)
    );

    cmp_timer24_counter #(.HALF_W(HALF_W)) u_cnt (
        .clk         (clk),
        .rst         (rst),
        .tick_en     (tick_en),
        .reload_mode (reload_mode),
        .wr_cnt_lo   (strb.cnt_lo),
        .wr_cnt_hi   (strb.cnt_hi),
        .wr_lat_lo   (strb.lat_lo),
        .wr_lat_hi   (strb.lat_hi),
        .wdata       (bus_wdata),
        .cnt_q       (cnt_q),
        .latch_q     (latch_q)
    );

    cmp_timer24_compare #(.HALF_W(HALF_W)) u_cmp (
        .clk       (clk),
        .rst       (rst),
        .wr_cmp_lo (strb.cmp_lo),
        .wr_cmp_hi (strb.cmp_hi),
        .wr_cnt_hi (strb.cnt_hi),
        .flag_clr  (flag_clr),
        .wdata     (bus_wdata),
        .cnt_q     (cnt_q),
        .cmp_q     (cmp_q),
        .flag_q    (cmp_flag)
    );

    always_comb begin
        case (bus_addr)
            REG_CNT_LO: bus_rdata = cnt_q[HALF_W-1:0];
            REG_CNT_HI: bus_rdata = cnt_q[CNT_W-1:HALF_W];
            REG_LAT_LO: bus_rdata = latch_q[HALF_W-1:0];
            REG_LAT_HI: bus_rdata = latch_q[CNT_W-1:HALF_W];
            REG_CMP_LO: bus_rdata = cmp_q[HALF_W-1:0];
            REG_CMP_HI: bus_rdata = cmp_q[CNT_W-1:HALF_W];
            default:    bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/cmp_timer24_chk.sv
module cmp_timer24_chk #(
    parameter int HALF_W = 12
) (
    input logic                clk,
    input logic                rst,
    input logic                bus_cs,
    input logic                bus_we,
    input logic [2:0]          bus_addr,
    input logic [HALF_W-1:0]   bus_wdata,
    input logic                tick_en,
    input logic                reload_mode,
    input logic                flag_clr,
    input logic                cmp_flag,
    input logic [2*HALF_W-1:0] cnt_q,
    input logic [2*HALF_W-1:0] latch_q,
    input logic [2*HALF_W-1:0] cmp_q
);
    localparam int CNT_W = 2 * HALF_W;
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic hi_wr;
    assign hi_wr = bus_cs && bus_we && (bus_addr == 3'd1);

    p_cnthi_load_r3: assert property (@(posedge clk) disable iff (rst)
        hi_wr |=> (cnt_q == {$past(bus_wdata), $past(latch_q[HALF_W-1:0])}));

    p_step_r5: assert property (@(posedge clk) disable iff (rst)
        (!hi_wr && tick_en && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + 1'b1));

    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (!hi_wr && !tick_en) |=> $stable(cnt_q));

    p_wrap_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (!hi_wr && tick_en && cnt_q == CNT_MAX && !reload_mode) |=> (cnt_q == '0));

    p_wrap_reload_r7: assert property (@(posedge clk) disable iff (rst)
        (!hi_wr && tick_en && cnt_q == CNT_MAX && reload_mode) |=> (cnt_q == $past(latch_q)));

    p_no_rise_below_r8: assert property (@(posedge clk) disable iff (rst)
        (!(cnt_q > cmp_q) && !cmp_flag) |=> !cmp_flag);

    p_clear_on_hiwr_r10: assert property (@(posedge clk) disable iff (rst)
        hi_wr |=> !cmp_flag);
endmodule

bind cmp_timer24 cmp_timer24_chk #(.HALF_W(HALF_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_cs      (bus_cs),
    .bus_we      (bus_we),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .tick_en     (tick_en),
    .reload_mode (reload_mode),
    .flag_clr    (flag_clr),
    .cmp_flag    (cmp_flag),
    .cnt_q       (cnt_q),
    .latch_q     (latch_q),
    .cmp_q       (cmp_q)
);

// File: tb/cmp_timer24_tb.sv
module cmp_timer24_tb;
    localparam int HW = 12;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_cs = 1'b0;
    logic          bus_we = 1'b0;
    logic [2:0]    bus_addr = '0;
    logic [HW-1:0] bus_wdata = '0;
    logic [HW-1:0] bus_rdata;
    logic          tick_en = 1'b0;
    logic          reload_mode = 1'b0;
    logic          flag_clr = 1'b0;
    logic          cmp_flag;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    cmp_timer24 #(.HALF_W(HW)) u_dut (
        .clk(clk), .rst(rst), .bus_cs(bus_cs), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tick_en(tick_en), .reload_mode(reload_mode),
        .flag_clr(flag_clr), .cmp_flag(cmp_flag)
    );

    // {is_write, addr, data, expected read}
    localparam int NV = 19;
    localparam logic [27:0] VEC [NV] = '{
        {1'b1, 3'd2, 12'h123, 12'h000},
        {1'b0, 3'd2, 12'h000, 12'h123},
        {1'b1, 3'd3, 12'hABC, 12'h000},
        {1'b0, 3'd3, 12'h000, 12'hABC},
        {1'b1, 3'd4, 12'h456, 12'h000},
        {1'b0, 3'd4, 12'h000, 12'h456},
        {1'b1, 3'd5, 12'h789, 12'h000},
        {1'b0, 3'd5, 12'h000, 12'h789},
        {1'b1, 3'd0, 12'h321, 12'h000},
        {1'b0, 3'd2, 12'h000, 12'h321},
        {1'b0, 3'd0, 12'h000, 12'h000},
        {1'b1, 3'd1, 12'h0F0, 12'h000},
        {1'b0, 3'd0, 12'h000, 12'h321},
        {1'b0, 3'd1, 12'h000, 12'h0F0},
        {1'b0, 3'd3, 12'h000, 12'hABC},
        {1'b1, 3'd6, 12'h777, 12'h000},
        {1'b0, 3'd6, 12'h000, 12'h000},
        {1'b0, 3'd7, 12'h000, 12'h000},
        {1'b0, 3'd4, 12'h000, 12'h456}
    };

    task automatic check(input string tag, input logic [HW-1:0] got, input logic [HW-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [HW-1:0] d);
        @(negedge clk);
        bus_cs = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_cs = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [HW-1:0] d);
        @(negedge clk);
        bus_cs = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_cs = 1'b0;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick_en = 1'b1;
        repeat (n) @(posedge clk);
        #1 tick_en = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk);
        flag_clr = 1'b1;
        @(posedge clk); #1;
        flag_clr = 1'b0;
    endtask

    logic done = 1'b0;

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got hang expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [HW-1:0] r;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: reset values
        bus_read(3'd0, r); check("R1 cnt lo", r, 12'h000);
        bus_read(3'd1, r); check("R1 cnt hi", r, 12'h000);
        bus_read(3'd2, r); check("R1 latch lo", r, 12'h000);
        bus_read(3'd3, r); check("R1 latch hi", r, 12'h000);
        bus_read(3'd4, r); check("R1 cmp lo", r, 12'hFFF);
        bus_read(3'd5, r); check("R1 cmp hi", r, 12'hFFF);
        check("R1 flag", {11'b0, cmp_flag}, 12'h000);

        // R2, R3, R4: register table
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][27]) begin
                bus_write(VEC[i][26:24], VEC[i][23:12]);
            end else begin
                bus_read(VEC[i][26:24], r);
                check($sformatf("R2/R3/R4 table entry %0d", i), r, VEC[i][11:0]);
            end
        end

        // R8: counter 3, compare 5; equality does not set, 6 sets one cycle later
        bus_write(3'd0, 12'h003);
        bus_write(3'd1, 12'h000);
        bus_write(3'd4, 12'h005);
        bus_write(3'd5, 12'h000);
        ticks(3);
        check("R8 flag low at equality edge", {11'b0, cmp_flag}, 12'h000);
        bus_read(3'd0, r); check("R5 count after 3 ticks", r, 12'h006);
        @(posedge clk); #1;
        check("R8 flag set after crossing", {11'b0, cmp_flag}, 12'h001);

        // R10 clear input, R9 no re-set while above
        pulse_clr();
        check("R10 flag cleared by flag_clr", {11'b0, cmp_flag}, 12'h000);
        ticks(4);
        repeat (2) @(posedge clk); #1;
        check("R9 flag stays low while above", {11'b0, cmp_flag}, 12'h000);

        // R10: count-high write clears
        bus_write(3'd1, 12'h000);
        ticks(3);
        @(posedge clk); #1;
        check("R8 flag set on second crossing", {11'b0, cmp_flag}, 12'h001);
        bus_write(3'd1, 12'h000);
        check("R10 flag cleared by count-high write", {11'b0, cmp_flag}, 12'h000);

        // R6: free wrap
        reload_mode = 1'b0;
        bus_write(3'd0, 12'hFFE);
        bus_write(3'd1, 12'hFFF);
        ticks(2);
        bus_read(3'd0, r); check("R6 wrap lo", r, 12'h000);
        bus_read(3'd1, r); check("R6 wrap hi", r, 12'h000);

        // R7: reload wrap
        bus_write(3'd1, 12'hFFF);
        bus_write(3'd2, 12'h010);
        bus_write(3'd3, 12'h002);
        reload_mode = 1'b1;
        ticks(2);
        bus_read(3'd0, r); check("R7 reload lo", r, 12'h010);
        bus_read(3'd1, r); check("R7 reload hi", r, 12'h002);

        // R5: hold without tick
        repeat (3) @(posedge clk);
        bus_read(3'd0, r); check("R5 hold lo", r, 12'h010);
        ticks(1);
        bus_read(3'd0, r); check("R5 single step", r, 12'h011);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule